// File: doc/BRIEF.md
# Stochastic Bivariate Bernstein Evaluator

This block evaluates a two-variable Bernstein polynomial of degree (DEG_A, DEG_B) by serial stochastic computing. Two input levels and a grid of (DEG_A+1)(DEG_B+1) coefficients are held as VAL_W-bit fractions of one. Each fraction is turned into a random bit stream whose density of ones equals the fraction. One stream is made per decoder input and one per coefficient. Every cycle the block counts how many of the DEG_A copies of the first input stream are 1, and how many of the DEG_B copies of the second are 1. The two counts pick one coefficient stream, and its bit becomes the output bit for that cycle.

Because the counts follow binomial laws, the density of ones at the output equals the polynomial value. A run lasts 2^VAL_W cycles. The ones seen at the output during the run form a VAL_W-bit result, which is a fraction of full scale. Software first loads the levels and coefficients through a write port. It then pulses `start` and waits for the one-cycle `done` strobe.

Top module: `bern_eval`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0.
- R2: A write while idle stores `wrData` as follows. Address i1*(DEG_B+1)+i2 holds coefficient b[i1][i2]. Address (DEG_A+1)(DEG_B+1) holds the first input level, and the next address holds the second. Writes made during an evaluation are dropped.
- R3: A `start` sampled while idle begins an evaluation. `done` rises exactly 2^VAL_W clock edges after the edge that sampled `start`.
- R4: A `start` pulse during an evaluation has no effect. The run in progress ends at its original time.
- R5: A stored level v gives a stream whose bits are 1 with density close to v/2^VAL_W. A level of 0 gives a stream that is never 1.
- R6: In every cycle, each count decoder drives exactly one of its outputs. The active output is the index equal to the number of its input streams that are 1.
- R7: The output bit is coefficient stream b[i1][i2], where i1 and i2 are the two decoder counts. With both levels 0, the result equals the ones density of b[0][0] alone: v-1 or v for a stored coefficient v.
- R8: With all coefficients 0, the result is exactly 0 for any levels.
- R9: The result lies within 8 percent of full scale of 2^VAL_W times the Bernstein polynomial value at (t1, t2) = (level1, level2)/2^VAL_W.
- R10: The result saturates at 2^VAL_W-1. It is held unchanged until the next `done`.
- R11: `done` is high for exactly one cycle per evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one evaluation when idle |
| wrEn | input | 1 | Write strobe for the level/coefficient store |
| wrAddr | input | ADDR_W | Store address (coefficients, then level 1, then level 2) |
| wrData | input | VAL_W | Fraction of one, scaled by 2^VAL_W |
| result | output | VAL_W | Ones counted over the last run, saturated |
| done | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The bench builds the block with VAL_W = 10, DEG_A = 2 and DEG_B = 3. This gives runs of 1024 cycles, short enough for several evaluations. It also gives an asymmetric 3-by-4 coefficient grid, so a swap of the two axes or a wrong row stride in the address map would be visible. The longer stream keeps the statistical error well inside the tolerance band. With one degree differing from the other, an off-by-one decoder on either side moves the result at the polynomial test points. At both levels 0, only coefficient b[0][0] is selected. At that corner the result is exact to one count, which makes the stream density and the selection path checkable without tolerance.

// File: rtl/bern_pkg.sv
package bern_pkg;

  typedef struct packed {
    logic clr;   // begin a run: clear counters
    logic acc;   // accumulate the output bit this cycle
    logic fin;   // last cycle of the run: latch result
    logic wrOk;  // store write accepted
  } ctlStrb_t;

  // Fibonacci feedback masks for maximal-length sequences, shift-left form
  function automatic logic [15:0] lfsrTaps(input int w);
    case (w)
      4:  return 16'h000C;
      5:  return 16'h0014;
      6:  return 16'h0030;
      7:  return 16'h0060;
      8:  return 16'h00B8;
      9:  return 16'h0110;
      10: return 16'h0240;
      11: return 16'h0500;
      default: return 16'h0829;
    endcase
  endfunction

  function automatic int seedFor(input int k, input int w);
    int s;
    s = (k * 937 + 31) % (1 << w);
    if (s == 0) s = 1;
    return s;
  endfunction

endpackage

// File: rtl/bern_streams.sv
module bern_streams #(
  parameter int VAL_W = 8,
  parameter int NUM   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM*VAL_W-1:0] levels,
  output logic [NUM-1:0]       bits
);
  localparam logic [VAL_W-1:0] TAPS = VAL_W'(bern_pkg::lfsrTaps(VAL_W));

  for (genvar k = 0; k < NUM; k++) begin : g_src
    localparam logic [VAL_W-1:0] SEED = VAL_W'(bern_pkg::seedFor(k, VAL_W));
    localparam int ROT = k % VAL_W;
    logic [VAL_W-1:0]   st;
    logic [2*VAL_W-1:0] dbl;
    logic [VAL_W-1:0]   rotd;

    always_ff @(posedge clk) begin
      if (!rstN) st <= SEED;
      else       st <= {st[VAL_W-2:0], ^(st & TAPS)};
    end

    // per-stream rotation decorrelates streams drawn from one polynomial
    assign dbl  = {st, st};
    assign rotd = dbl[2*VAL_W-1-ROT -: VAL_W];
    assign bits[k] = rotd < levels[k*VAL_W +: VAL_W];
  end

endmodule

// File: rtl/bern_countdec.sv
module bern_countdec #(
  parameter int N = 2
) (
  input  logic [N-1:0] in,
  output logic [N:0]   sel
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(in[i]);
    sel = '0;
    sel[cnt] = 1'b1;
  end

endmodule

// File: rtl/bern_datapath.sv
module bern_datapath #(
  parameter int VAL_W  = 8,
  parameter int DEG_A  = 2,
  parameter int DEG_B  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  bern_pkg::ctlStrb_t  strb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [VAL_W-1:0]    wrData,
  output logic [VAL_W-1:0]    result
);
  localparam int COEF_N = (DEG_A + 1) * (DEG_B + 1);
  localparam int NSTR   = DEG_A + DEG_B + COEF_N;
  localparam logic [VAL_W:0] FULL = {1'b1, {VAL_W{1'b0}}};

  logic [VAL_W-1:0]        levelA, levelB;
  logic [VAL_W-1:0]        coef [COEF_N];
  logic [NSTR*VAL_W-1:0]   levels;
  logic [NSTR-1:0]         bits;
  logic [DEG_A:0]          selA;
  logic [DEG_B:0]          selB;
  logic                    outBit;
  logic [VAL_W:0]          onesCnt, nextCnt;

  // store
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelA <= '0;
      levelB <= '0;
      for (int k = 0; k < COEF_N; k++) coef[k] <= '0;
    end else if (strb.wrOk) begin
      if (wrAddr < ADDR_W'(COEF_N))       coef[wrAddr] <= wrData;
      else if (wrAddr == ADDR_W'(COEF_N)) levelA <= wrData;
      else if (wrAddr == ADDR_W'(COEF_N + 1)) levelB <= wrData;
    end
  end

  // stream levels: first axis copies, second axis copies, coefficients
  for (genvar a = 0; a < DEG_A; a++) begin : g_lvA
    assign levels[a*VAL_W +: VAL_W] = levelA;
  end
  for (genvar b = 0; b < DEG_B; b++) begin : g_lvB
    assign levels[(DEG_A+b)*VAL_W +: VAL_W] = levelB;
  end
  for (genvar c = 0; c < COEF_N; c++) begin : g_lvC
    assign levels[(DEG_A+DEG_B+c)*VAL_W +: VAL_W] = coef[c];
  end

  bern_streams #(.VAL_W(VAL_W), .NUM(NSTR)) u_streams (
    .clk(clk), .rstN(rstN), .levels(levels), .bits(bits)
  );

  bern_countdec #(.N(DEG_A)) u_decA (.in(bits[DEG_A-1:0]), .sel(selA));
  bern_countdec #(.N(DEG_B)) u_decB (.in(bits[DEG_A+DEG_B-1:DEG_A]), .sel(selB));

  always_comb begin
    outBit = 1'b0;
    for (int i = 0; i <= DEG_A; i++)
      for (int j = 0; j <= DEG_B; j++)
        outBit = outBit | (selA[i] & selB[j] & bits[DEG_A + DEG_B + i*(DEG_B+1) + j]);
  end

  assign nextCnt = onesCnt + {{VAL_W{1'b0}}, outBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesCnt <= '0;
      result  <= '0;
    end else begin
      if (strb.clr)      onesCnt <= '0;
      else if (strb.acc) onesCnt <= nextCnt;
      if (strb.fin) result <= nextCnt[VAL_W] ? {VAL_W{1'b1}} : nextCnt[VAL_W-1:0];
    end
  end

  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(selA) && $onehot(selB));

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= FULL);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fin |=> $stable(result));

endmodule

// File: rtl/bern_ctrl.sv
module bern_ctrl #(
  parameter int VAL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               wrEn,
  output bern_pkg::ctlStrb_t strb,
  output logic               done
);
  logic             busy;
  logic [VAL_W-1:0] cycCnt;

  assign strb.clr  = start & ~busy;
  assign strb.acc  = busy;
  assign strb.fin  = busy & (cycCnt == {VAL_W{1'b1}});
  assign strb.wrOk = wrEn & ~busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cycCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= strb.fin;
      if (strb.clr) begin
        busy   <= 1'b1;
        cycCnt <= '0;
      end else if (busy) begin
        cycCnt <= cycCnt + 1'b1;
        if (strb.fin) busy <= 1'b0;
      end
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.fin) |=> busy);

  p_no_write_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.wrOk);

endmodule

// File: rtl/bern_eval.sv
module bern_eval #(
  parameter int VAL_W = 8,
  parameter int DEG_A = 2,
  parameter int DEG_B = 2,
  localparam int ADDR_W = $clog2((DEG_A + 1) * (DEG_B + 1) + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [VAL_W-1:0]  wrData,
  output logic [VAL_W-1:0]  result,
  output logic              done
);
  bern_pkg::ctlStrb_t strb;

  bern_ctrl #(.VAL_W(VAL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn), .strb(strb), .done(done)
  );

  bern_datapath #(.VAL_W(VAL_W), .DEG_A(DEG_A), .DEG_B(DEG_B), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData), .result(result)
  );

endmodule

// File: tb/sim_bern_eval.sv
module sim_bern_eval;
  localparam int W = 10;
  localparam int DA = 2;
  localparam int DB = 3;
  localparam int NC = (DA + 1) * (DB + 1);
  localparam int AW = $clog2(NC + 2);
  localparam int FULLSCALE = 1 << W;
  localparam int TOL = 82;

  logic clk = 0, rstN = 0, start = 0, wrEn = 0;
  logic [AW-1:0] wrAddr = '0;
  logic [W-1:0]  wrData = '0;
  logic [W-1:0]  result;
  logic          done;

  int nRun = 0, nFail = 0;
  int cf [NC];

  always #2 clk = ~clk;

  bern_eval #(.VAL_W(W), .DEG_A(DA), .DEG_B(DB)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .result(result), .done(done)
  );

  task automatic check(input string req, input int act, input int expLo, input int expHi);
    nRun++;
    if (act < expLo || act > expHi) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, expLo, expHi);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1; wrAddr = AW'(addr); wrData = W'(data);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic loadAll(input int t1, input int t2);
    for (int k = 0; k < NC; k++) wr(k, cf[k]);
    wr(NC, t1);
    wr(NC + 1, t2);
  endtask

  // pulse start, optionally disturb mid-run, return latency and result
  task automatic runEval(input bit disturb, output int lat, output int res);
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    lat = 0;
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (disturb && lat == 100) begin
        wrEn = 1; wrAddr = '0; wrData = '1; start = 1;
      end else begin
        wrEn = 0; start = 0;
      end
      if (done) break;
    end
    res = result;
    @(negedge clk);
    check("R11 done one cycle", int'(done), 0, 0);
    repeat (5) @(negedge clk);
    check("R10 result held", int'(result), res, res);
  endtask

  function automatic real choose(input int n, input int k);
    real r = 1.0;
    for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
    return r;
  endfunction

  function automatic real bern(input real x, input real y);
    real s = 0.0;
    for (int i = 0; i <= DA; i++)
      for (int j = 0; j <= DB; j++)
        s += (real'(cf[i*(DB+1)+j]) / FULLSCALE)
             * choose(DA, i) * (x ** i) * ((1.0 - x) ** (DA - i))
             * choose(DB, j) * (y ** j) * ((1.0 - y) ** (DB - j));
    return s;
  endfunction

  task automatic tReset();
    check("R1 reset result", int'(result), 0, 0);
    check("R1 reset done", int'(done), 0, 0);
  endtask

  task automatic tZeroCoef();
    int lat, res;
    for (int k = 0; k < NC; k++) cf[k] = 0;
    loadAll(500, 700);
    runEval(0, lat, res);
    check("R3 latency", lat, FULLSCALE, FULLSCALE);
    check("R8 zero coefficients", res, 0, 0);
  endtask

  task automatic tBusyIgnore();
    int lat, res;
    for (int k = 0; k < NC; k++) cf[k] = 0;
    loadAll(0, 0);
    runEval(1, lat, res);
    check("R4 start ignored while busy", lat, FULLSCALE, FULLSCALE);
    check("R2 write ignored while busy", res, 0, 0);
    runEval(0, lat, res);
    check("R2 dropped write left store unchanged", res, 0, 0);
  endtask

  task automatic tCorner();
    int lat, res;
    for (int k = 0; k < NC; k++) cf[k] = FULLSCALE - 1;
    cf[0] = 600;
    loadAll(0, 0);
    runEval(0, lat, res);
    check("R7 both levels zero selects b00 (R5 density)", res, 599, 600);
  endtask

  task automatic tPoly(input int t1, input int t2, input string tag);
    int lat, res, e;
    loadAll(t1, t2);
    runEval(0, lat, res);
    e = int'(bern(real'(t1) / FULLSCALE, real'(t2) / FULLSCALE) * FULLSCALE);
    check({"R9 polynomial ", tag}, res, e - TOL, e + TOL);
    check("R3 latency", lat, FULLSCALE, FULLSCALE);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    tZeroCoef();
    tBusyIgnore();
    tCorner();
    for (int k = 0; k < NC; k++) cf[k] = 600;
    tPoly(400, 600, "constant grid");
    for (int k = 0; k < NC; k++) cf[k] = (k * 283 + 97) % 1000;
    tPoly(300, 700, "p1");
    tPoly(512, 512, "p2");
    tPoly(850, 200, "p3");
    for (int k = 0; k < NC; k++) cf[k] = (k % 2 == 0) ? 900 : 100;
    tPoly(650, 350, "p4 (R6 counts drive selection)");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule